// File: doc/BRIEF.md
# Write-Once RTC Clock Source Selector

This block picks the kernel clock for a real-time counter from three candidates: a low-speed crystal, a low-speed on-chip oscillator, or the fast crystal clock after a programmable divider. The selection can be written once. After a nonzero code has been accepted, the choice is frozen and every later write is dropped. Only the backup-domain reset can clear it.

The block works in a single clock domain. Each candidate clock arrives as a one-cycle enable pulse on `clk`. The selected source is returned as `rtc_tick`, a one-cycle enable pulse. The fast path counts `hse_pulse` strobes and emits one tick every N strobes. N is taken from the prescaler field, and the intended output rate is about 1 MHz.

Top module: `rtc_clk_sel`

## Requirements
- R1: While `bkp_rst_n` is low, and in the first cycle after it goes high, `sel_q` is 00, `locked` is 0 and `rtc_tick` is 0.
- R2: While unlocked, a `sel_wr` strobe with a nonzero `sel_code` makes `sel_q` equal that code and raises `locked` in the next cycle. The code values are 01 for the low-speed crystal, 10 for the low-speed internal oscillator and 11 for the divided fast clock.
- R3: A `sel_wr` strobe with code 00 changes nothing: `sel_q` stays 00 and `locked` stays 0.
- R4: While `locked` is 1, `sel_wr` strobes have no effect on `sel_q` or `locked`.
- R5: Only a low level on `bkp_rst_n` returns a locked selector to `sel_q` = 00 and `locked` = 0. After that, a new nonzero write is accepted.
- R6: With `sel_q` = 01, `rtc_tick` equals `lse_pulse` in the same cycle. With 10, it equals `lsi_pulse`. With 00, it is always 0.
- R7: With `sel_q` = 11 and `hse_presc` = N in the range 2..31, the divider counts `hse_pulse` strobes starting from zero. `rtc_tick` is high for exactly one cycle, in the cycle after the N-th strobe is sampled, and counting then starts again.
- R8: A `hse_presc` value of 0 or 1 produces no ticks and keeps the count at zero.
- R9: A cycle in which `hse_presc` differs from its value in the previous cycle resets the count to zero and produces no tick. The divider is also held at zero while `sel_q` is not 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| bkp_rst_n | input | 1 | Backup-domain reset, active low, asynchronous |
| sel_wr | input | 1 | Source-select write strobe |
| sel_code | input | 2 | Source code to write |
| hse_presc | input | PRESC_W | Fast-clock division ratio |
| lse_pulse | input | 1 | Low-speed crystal clock enable |
| lsi_pulse | input | 1 | Low-speed internal oscillator enable |
| hse_pulse | input | 1 | Fast crystal clock enable |
| rtc_tick | output | 1 | Selected RTC clock enable |
| sel_q | output | 2 | Currently latched source code |
| locked | output | 1 | Selection frozen flag |

## Verification
The bench builds the block with the default 5-bit prescaler width. This puts the largest ratio of 31 and both illegal values, 0 and 1, within a short run. A cycle model in the bench predicts every output cycle. It covers continuous and gapped fast strobes, ratio changes in the middle of a count, and locking attempts both before and after a backup reset.

// File: rtl/rtc_clk_sel_pkg.sv
package rtc_clk_sel_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_LSE  = 2'b01,
    SRC_LSI  = 2'b10,
    SRC_HSE  = 2'b11
  } rtc_src_e;
endpackage

// File: rtl/rtc_src_lock.sv
module rtc_src_lock
  import rtc_clk_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [1:0] code_i,
  output rtc_src_e   src_o,
  output logic       locked_o
);
  logic accept_w;
  assign accept_w = wr_i && !locked_o && (code_i != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_o    <= SRC_NONE;
      locked_o <= 1'b0;
    end else if (accept_w) begin
      src_o    <= rtc_src_e'(code_i);
      locked_o <= 1'b1;
    end
  end

  assert_lock_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !locked_o && code_i != 2'b00) |=> (locked_o && src_o == rtc_src_e'($past(code_i))));
  assert_zero_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_o && !(wr_i && code_i != 2'b00)) |=> (!locked_o && src_o == SRC_NONE));
  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> (locked_o && $stable(src_o)));
endmodule

// File: rtl/rtc_hse_div.sv
module rtc_hse_div #(
  parameter int PRESC_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               pulse_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  localparam int CNT_W = PRESC_W;

  function automatic logic presc_ok(input logic [PRESC_W-1:0] p);
    return p >= PRESC_W'(2);
  endfunction

  function automatic logic at_wrap(input logic [CNT_W-1:0] c, input logic [PRESC_W-1:0] p);
    return c == CNT_W'(p - PRESC_W'(1));
  endfunction

  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               presc_chg_w, run_w, wrap_w;

  assign presc_chg_w = presc_i != presc_q;
  assign run_w       = en_i && !presc_chg_w && presc_ok(presc_i);
  assign wrap_w      = run_w && pulse_i && at_wrap(cnt_q, presc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
      tick_o  <= 1'b0;
    end else begin
      presc_q <= presc_i;
      tick_o  <= wrap_w;
      if (!run_w)       cnt_q <= '0;
      else if (wrap_w)  cnt_q <= '0;
      else if (pulse_i) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  assert_no_tick_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_i < PRESC_W'(2)) |=> (!tick_o && cnt_q == '0));
  assert_restart_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_i != presc_q) |=> (!tick_o && cnt_q == '0));
endmodule

// File: rtl/rtc_tick_mux.sv
module rtc_tick_mux
  import rtc_clk_sel_pkg::*;
(
  input  rtc_src_e src_i,
  input  logic     lse_i,
  input  logic     lsi_i,
  input  logic     hse_div_i,
  output logic     tick_o
);
  always_comb begin
    unique case (src_i)
      SRC_LSE: tick_o = lse_i;
      SRC_LSI: tick_o = lsi_i;
      SRC_HSE: tick_o = hse_div_i;
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtc_clk_sel.sv
module rtc_clk_sel
  import rtc_clk_sel_pkg::*;
#(
  parameter int PRESC_W = 5
) (
  input  logic               clk,
  input  logic               bkp_rst_n,
  input  logic               sel_wr,
  input  logic [1:0]         sel_code,
  input  logic [PRESC_W-1:0] hse_presc,
  input  logic               lse_pulse,
  input  logic               lsi_pulse,
  input  logic               hse_pulse,
  output logic               rtc_tick,
  output logic [1:0]         sel_q,
  output logic               locked
);
  rtc_src_e src_w;
  logic     hse_div_tick_w;
  logic     hse_run_w;

  assign hse_run_w = (src_w == SRC_HSE);

  rtc_src_lock u_lock (
    .clk      (clk),
    .rst_n    (bkp_rst_n),
    .wr_i     (sel_wr),
    .code_i   (sel_code),
    .src_o    (src_w),
    .locked_o (locked)
  );

  rtc_hse_div #(.PRESC_W(PRESC_W)) u_div (
    .clk     (clk),
    .rst_n   (bkp_rst_n),
    .en_i    (hse_run_w),
    .pulse_i (hse_pulse),
    .presc_i (hse_presc),
    .tick_o  (hse_div_tick_w)
  );

  rtc_tick_mux u_mux (
    .src_i     (src_w),
    .lse_i     (lse_pulse),
    .lsi_i     (lsi_pulse),
    .hse_div_i (hse_div_tick_w),
    .tick_o    (rtc_tick)
  );

  assign sel_q = src_w;

  assert_idle_silent_R6: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    (sel_q == 2'b00) |-> (!rtc_tick && !locked));
  assert_divider_gated_R9: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    (sel_q != 2'b11) |=> !hse_div_tick_w);
endmodule

// File: tb/rtc_clk_sel_bench.sv
module rtc_clk_sel_bench;
  localparam int PW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          bkp_rst_n = 1'b0;
  logic          sel_wr = 1'b0;
  logic [1:0]    sel_code = 2'b00;
  logic [PW-1:0] hse_presc = '0;
  logic          lse_pulse = 1'b0, lsi_pulse = 1'b0, hse_pulse = 1'b0;
  logic          rtc_tick, locked;
  logic [1:0]    sel_q;

  rtc_clk_sel #(.PRESC_W(PW)) u_rtc_clk_sel (
    .clk(clk), .bkp_rst_n(bkp_rst_n), .sel_wr(sel_wr), .sel_code(sel_code),
    .hse_presc(hse_presc), .lse_pulse(lse_pulse), .lsi_pulse(lsi_pulse),
    .hse_pulse(hse_pulse), .rtc_tick(rtc_tick), .sel_q(sel_q), .locked(locked)
  );

  typedef struct {
    logic       tick;
    logic [1:0] sel;
    logic       lock;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state, advanced once per rising edge
  logic [1:0] m_sel = 2'b00;
  logic       m_lock = 1'b0;
  int         m_cnt = 0;
  int         m_prev_presc = 0;
  logic       m_div = 1'b0;

  task automatic drive(input logic rst_n, input logic wr, input logic [1:0] code,
                       input int presc, input logic lse, input logic lsi,
                       input logic hse, input string tag);
    exp_t e;
    logic [1:0] old_sel;
    @(negedge clk);
    bkp_rst_n = rst_n; sel_wr = wr; sel_code = code; hse_presc = PW'(presc);
    lse_pulse = lse; lsi_pulse = lsi; hse_pulse = hse;
    if (!rst_n) begin
      m_sel = 2'b00; m_lock = 1'b0; m_cnt = 0; m_prev_presc = 0; m_div = 1'b0;
    end else begin
      old_sel = m_sel;
      if (wr && !m_lock && code != 2'b00) begin
        m_sel = code; m_lock = 1'b1;
      end
      m_div = 1'b0;
      if (old_sel != 2'b11 || presc != m_prev_presc || presc < 2) m_cnt = 0;
      else if (hse) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == presc) begin m_div = 1'b1; m_cnt = 0; end
      end
      m_prev_presc = presc;
    end
    case (m_sel)
      2'b01:   e.tick = lse;
      2'b10:   e.tick = lsi;
      2'b11:   e.tick = m_div;
      default: e.tick = 1'b0;
    endcase
    e.sel = m_sel; e.lock = m_lock; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares one expected item per edge, 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (rtc_tick !== e.tick || sel_q !== e.sel || locked !== e.lock) begin
          errors++;
          $display("FAIL %s: tick/sel/locked actual %b/%b/%b expected %b/%b/%b",
                   e.tag, rtc_tick, sel_q, locked, e.tick, e.sel, e.lock);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) drive(0, 1, 2'b01, 5, 1, 1, 1, "R1");
    drive(1, 0, 2'b00, 0, 1, 1, 1, "R1");
    // R3 zero code ignored
    for (int i = 0; i < 3; i++) drive(1, 1, 2'b00, 0, i[0], 1, 1, "R3");
    // R2 accept crystal source, R6 passes its pulses
    drive(1, 1, 2'b01, 0, 1, 0, 0, "R2");
    for (int i = 0; i < 12; i++) drive(1, 0, 2'b00, 0, (i % 3) == 0, (i % 2) == 0, 1, "R6");
    // R4 later writes dropped
    drive(1, 1, 2'b10, 0, 0, 1, 0, "R4");
    drive(1, 1, 2'b11, 7, 1, 0, 1, "R4");
    for (int i = 0; i < 4; i++) drive(1, 1, 2'(i), 3, i[0], 1, 1, "R4");
    // R5 backup reset clears, then new choice accepted
    drive(0, 0, 2'b00, 0, 1, 1, 1, "R5");
    drive(1, 0, 2'b00, 0, 1, 1, 1, "R5");
    drive(1, 1, 2'b10, 0, 0, 1, 0, "R5");
    for (int i = 0; i < 10; i++) drive(1, 0, 2'b00, 0, (i % 2) == 1, (i % 4) == 0, 1, "R6");
    // divided fast path
    drive(0, 0, 2'b00, 5, 0, 0, 0, "R1");
    drive(1, 1, 2'b11, 5, 0, 0, 1, "R7");
    for (int i = 0; i < 25; i++) drive(1, 0, 2'b00, 5, 1, 1, 1, "R7");
    for (int i = 0; i < 24; i++) drive(1, 0, 2'b00, 3, 0, 0, (i % 3) != 1, "R7");
    for (int i = 0; i < 3; i++) drive(1, 0, 2'b00, 2, 0, 0, 1, "R7");
    for (int i = 0; i < 12; i++) drive(1, 0, 2'b00, (i == 5) ? 6 : 4, 0, 0, 1, "R9");
    for (int i = 0; i < 10; i++) drive(1, 0, 2'b00, 1, 0, 0, 1, "R8");
    for (int i = 0; i < 10; i++) drive(1, 0, 2'b00, 0, 0, 0, 1, "R8");
    for (int i = 0; i < 70; i++) drive(1, 0, 2'b00, 31, 0, 0, 1, "R7");
    // divider held while another source is chosen
    drive(0, 0, 2'b00, 2, 0, 0, 1, "R9");
    drive(1, 1, 2'b10, 2, 0, 0, 1, "R9");
    for (int i = 0; i < 8; i++) drive(1, 0, 2'b00, 2, 0, 0, 1, "R9");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule